// File: doc/BRIEF.md
# I2C Status Flag and Clock-Stretch Controller

This block keeps the event and status flags of an I2C controller that a processor reads by polling or through an interrupt. A bit-level engine, which is outside this block, sends it single-cycle event pulses. Software activity reaches it as single-cycle access strobes: a status register read, a data register read, a data register write and a write of the start request bit. From these inputs the block drives five status flags, one interrupt line and a request to hold SCL low. The serial shifter, the pin drivers and the bus timing are outside this block.

Most flags are cleared by software in two steps. First software reads the status register while the flag is set. Then it performs one particular data register access. Each two-step flag is a small machine with three states. In `FLG_CLEAR` the flag is 0. In `FLG_PEND` the flag is 1 and the machine is waiting for a status read. In `FLG_ARMED` the flag is 1, a status read has been seen, and the machine is waiting for the data access that clears it. The transitions are:
- *raise*: any state goes to `FLG_PEND` on a set event.
- *arm*: `FLG_PEND` goes to `FLG_ARMED` on a status read with no data access in the same cycle.
- *release*: `FLG_ARMED` goes to `FLG_CLEAR` on the matching access.
- *disarm*: `FLG_ARMED` goes back to `FLG_PEND` on any other data access.
- *drop*: any state goes to `FLG_CLEAR` while the block is disabled.

The address-selected flag uses a one-step variant of the same machine. Its *release* goes straight from `FLG_PEND` on a status read.

The bus tracker has two states, `BUS_IDLE` and `BUS_ACTIVE`, with transitions *open* (start seen) and *close* (stop seen). The role tracker has two states, `ROLE_SLAVE` and `ROLE_MASTER`, with transitions *claim* (start request write) and *yield* (stop, arbitration loss or disable). The interrupt register has two states, `IRQ_QUIET` and `IRQ_RAISED`. The SCL hold request is taken straight from the flags that stall the bus.

Top module: `i2c_stat_stretch`

## Requirements
- R1: `st_busy` becomes 1 on the clock edge after `bus_start_seen` and 0 on the clock edge after `bus_stop_seen` (start wins if both arrive together). It follows the bus even while `if_en` is 0.
- R2: `st_byte_done` becomes 1 on the edge after `tx_ack_clk` (acknowledge clock received after a transmitted byte) or after `addr_acked` (address byte acknowledged). Either of these sets clear it to be a data register write.
- R3: `rx_ack_clk` (acknowledge clock sent after a received byte) sets `st_byte_done` only when `ack_en` is 1. This set makes the clearing access a data register read.
- R4: `st_byte_done` clears only on a data access of the expected kind that follows a status read. A status read alone leaves it at 1. A data access of the wrong kind, or one with no status read before it, leaves it at 1 and cancels any earlier status read.
- R5: `st_addr_sel` becomes 1 on the edge after `addr_hit` or `gen_call_hit`. It clears on the edge after a status read alone. A data register access alone does not clear it.
- R6: `st_start_sent` becomes 1 on the edge after `start_made`. It clears only on a status read followed by a data register write. A data register read in between cancels the status read.
- R7: `st_master` becomes 1 on the edge after `start_wr`. It becomes 0 on the edge after `bus_stop_seen` or `arb_lost`, and these take priority over `start_wr`.
- R8: While `if_en` is 0, `st_byte_done`, `st_addr_sel`, `st_start_sent` and `st_master` are 0 from the next edge on, and events do not set them.
- R9: A set event in the same cycle as the access that would clear a flag leaves that flag at 1.
- R10: `scl_hold_low` is 1 in exactly the cycles where `st_byte_done` or `st_addr_sel` is 1. It has no register delay.
- R11: `irq` is 1 one edge after a cycle in which `if_en` and `irq_en` are 1 and at least one of `st_byte_done`, `st_addr_sel`, `st_start_sent` is 1. Otherwise `irq` is 0.
- R12: After reset, all status outputs, `irq` and `scl_hold_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_en | input | 1 | Interface enable |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| bus_start_seen | input | 1 | Start condition detected on the bus |
| bus_stop_seen | input | 1 | Stop condition detected on the bus |
| start_made | input | 1 | Start condition generated by this controller |
| tx_ack_clk | input | 1 | Acknowledge clock received after a transmitted data byte |
| addr_acked | input | 1 | Sent address byte acknowledged |
| rx_ack_clk | input | 1 | Acknowledge clock sent after a received byte |
| addr_hit | input | 1 | Received slave address equals the own address |
| gen_call_hit | input | 1 | General call recognised |
| arb_lost | input | 1 | Arbitration lost |
| sr_rd | input | 1 | Status register read strobe |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| start_wr | input | 1 | Start request written as 1 |
| st_busy | output | 1 | Bus busy flag |
| st_byte_done | output | 1 | Byte transfer finished flag |
| st_addr_sel | output | 1 | Addressed as slave flag |
| st_master | output | 1 | Master role flag |
| st_start_sent | output | 1 | Start generated flag |
| irq | output | 1 | Interrupt request |
| scl_hold_low | output | 1 | Request to hold SCL low |

## Verification
Each flag comes from a single register. A strobe that is driven during one cycle therefore shows on its flag after the next rising edge. `irq` adds a second register, so it changes one edge after the flag it follows. `scl_hold_low` is combinational and changes in the same cycle as the flags. The bench drives every strobe for exactly one cycle starting at a falling edge. It reads flags and `scl_hold_low` at the following falling edge, and it waits one more cycle before it reads `irq`. Each two-step clear is checked at every step: after the status read, after any wrong access and after the correct access.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    typedef enum logic {
        BUS_IDLE   = 1'b0,
        BUS_ACTIVE = 1'b1
    } bus_state_e;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_kind_e;

    localparam int unsigned IRQ_SRC_N = 3;

endpackage

// File: rtl/i2c_sf_flag_fsm.sv
module i2c_sf_flag_fsm
    import i2c_sf_pkg::*;
#(
    parameter bit TWO_STEP = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      set_i,
    input  acc_kind_e set_kind_i,
    input  logic      sr_rd_i,
    input  logic      dr_rd_i,
    input  logic      dr_wr_i,
    output logic      flag_o
);

    flg_state_e state_q, state_d;
    acc_kind_e  kind_q, kind_d;
    logic       dr_any;
    logic       match_acc;
    logic       pend_release;
    logic       pend_arm;

    assign dr_any    = dr_rd_i | dr_wr_i;
    assign match_acc = (kind_q == ACC_READ) ? dr_rd_i : dr_wr_i;

    generate
        if (TWO_STEP) begin : g_two_step
            assign pend_release = 1'b0;
            assign pend_arm     = sr_rd_i & ~dr_any;
        end else begin : g_one_step
            assign pend_release = sr_rd_i;
            assign pend_arm     = 1'b0;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_CLEAR;
            kind_q  <= ACC_WRITE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        if (!en_i) begin
            state_d = FLG_CLEAR;                 // drop
        end else if (set_i) begin
            state_d = FLG_PEND;                  // raise
            kind_d  = set_kind_i;
        end else begin
            unique case (state_q)
                FLG_CLEAR: state_d = FLG_CLEAR;
                FLG_PEND: begin
                    if (pend_release)  state_d = FLG_CLEAR;   // one-step release
                    else if (pend_arm) state_d = FLG_ARMED;   // arm
                end
                FLG_ARMED: begin
                    if (match_acc)   state_d = FLG_CLEAR;     // release
                    else if (dr_any) state_d = FLG_PEND;      // disarm
                end
                default: state_d = FLG_CLEAR;
            endcase
        end
    end

    // outputs
    always_comb begin
        flag_o = (state_q != FLG_CLEAR);
    end

    assert_drop_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !flag_o);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i) |=> flag_o);

    generate
        if (TWO_STEP) begin : g_chk_two
            assert_no_early_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && !set_i && state_q == FLG_PEND) |=> flag_o);
        end else begin : g_chk_one
            assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && !set_i && flag_o && sr_rd_i) |=> !flag_o);
        end
    endgenerate

endmodule

// File: rtl/i2c_sf_bus_fsm.sv
module i2c_sf_bus_fsm
    import i2c_sf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_seen_i,
    input  logic stop_seen_i,
    input  logic arb_lost_i,
    input  logic start_wr_i,
    output logic busy_o,
    output logic master_o
);

    bus_state_e  bus_q, bus_d;
    role_state_e role_q, role_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q  <= BUS_IDLE;
            role_q <= ROLE_SLAVE;
        end else begin
            bus_q  <= bus_d;
            role_q <= role_d;
        end
    end

    // next state
    always_comb begin
        bus_d = bus_q;
        unique case (bus_q)
            BUS_IDLE:   if (start_seen_i) bus_d = BUS_ACTIVE;                      // open
            BUS_ACTIVE: if (stop_seen_i && !start_seen_i) bus_d = BUS_IDLE;        // close
            default:    bus_d = BUS_IDLE;
        endcase

        role_d = role_q;
        if (!en_i || stop_seen_i || arb_lost_i) begin
            role_d = ROLE_SLAVE;                                                   // yield
        end else begin
            unique case (role_q)
                ROLE_SLAVE:  if (start_wr_i) role_d = ROLE_MASTER;                 // claim
                ROLE_MASTER: role_d = ROLE_MASTER;
                default:     role_d = ROLE_SLAVE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o   = (bus_q == BUS_ACTIVE);
        master_o = (role_q == ROLE_MASTER);
    end

    assert_busy_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen_i |=> busy_o);

    assert_busy_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen_i && !start_seen_i) |=> !busy_o);

    assert_role_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen_i || arb_lost_i) |=> !master_o);

    assert_role_claims_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_wr_i && !stop_seen_i && !arb_lost_i) |=> master_o);

endmodule

// File: rtl/i2c_sf_irq.sv
module i2c_sf_irq
    import i2c_sf_pkg::*;
#(
    parameter int unsigned SRC_N = IRQ_SRC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ie_i,
    input  logic [SRC_N-1:0] pend_i,
    output logic             irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = (en_i && ie_i && (|pend_i)) ? IRQ_RAISED : IRQ_QUIET;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_i |=> !irq_o);

    assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o);

endmodule

// File: rtl/i2c_stat_stretch.sv
module i2c_stat_stretch
    import i2c_sf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic irq_en,
    input  logic ack_en,
    input  logic bus_start_seen,
    input  logic bus_stop_seen,
    input  logic start_made,
    input  logic tx_ack_clk,
    input  logic addr_acked,
    input  logic rx_ack_clk,
    input  logic addr_hit,
    input  logic gen_call_hit,
    input  logic arb_lost,
    input  logic sr_rd,
    input  logic dr_rd,
    input  logic dr_wr,
    input  logic start_wr,
    output logic st_busy,
    output logic st_byte_done,
    output logic st_addr_sel,
    output logic st_master,
    output logic st_start_sent,
    output logic irq,
    output logic scl_hold_low
);

    logic                 rx_set;
    logic                 tx_set;
    logic                 btf_set;
    acc_kind_e            btf_kind;
    logic [IRQ_SRC_N-1:0] pend_vec;

    assign rx_set   = rx_ack_clk & ack_en;
    assign tx_set   = tx_ack_clk | addr_acked;
    assign btf_set  = rx_set | tx_set;
    assign btf_kind = (rx_set && !tx_set) ? ACC_READ : ACC_WRITE;

    i2c_sf_bus_fsm u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (if_en),
        .start_seen_i (bus_start_seen),
        .stop_seen_i  (bus_stop_seen),
        .arb_lost_i   (arb_lost),
        .start_wr_i   (start_wr),
        .busy_o       (st_busy),
        .master_o     (st_master)
    );

    i2c_sf_flag_fsm #(.TWO_STEP(1'b1)) u_btf (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (if_en),
        .set_i      (btf_set),
        .set_kind_i (btf_kind),
        .sr_rd_i    (sr_rd),
        .dr_rd_i    (dr_rd),
        .dr_wr_i    (dr_wr),
        .flag_o     (st_byte_done)
    );

    i2c_sf_flag_fsm #(.TWO_STEP(1'b1)) u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (if_en),
        .set_i      (start_made),
        .set_kind_i (ACC_WRITE),
        .sr_rd_i    (sr_rd),
        .dr_rd_i    (dr_rd),
        .dr_wr_i    (dr_wr),
        .flag_o     (st_start_sent)
    );

    i2c_sf_flag_fsm #(.TWO_STEP(1'b0)) u_adsl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (if_en),
        .set_i      (addr_hit | gen_call_hit),
        .set_kind_i (ACC_WRITE),
        .sr_rd_i    (sr_rd),
        .dr_rd_i    (dr_rd),
        .dr_wr_i    (dr_wr),
        .flag_o     (st_addr_sel)
    );

    assign pend_vec = {st_start_sent, st_addr_sel, st_byte_done};

    i2c_sf_irq #(.SRC_N(IRQ_SRC_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (if_en),
        .ie_i   (irq_en),
        .pend_i (pend_vec),
        .irq_o  (irq)
    );

    always_comb begin
        scl_hold_low = st_byte_done | st_addr_sel;
    end

    assert_hold_on_btf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_byte_done |-> scl_hold_low);

    assert_hold_on_adsl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_addr_sel |-> scl_hold_low);

    assert_hold_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_byte_done && !st_addr_sel) |-> !scl_hold_low);

    assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_byte_done || st_addr_sel || st_start_sent));

    assert_rx_nack_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_byte_done && rx_ack_clk && !ack_en && !tx_ack_clk && !addr_acked) |=> !st_byte_done);

endmodule

// File: tb/i2c_stat_stretch_tb.sv
module i2c_stat_stretch_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_en = 1'b0, irq_en = 1'b0, ack_en = 1'b0;
    logic bus_start_seen = 1'b0, bus_stop_seen = 1'b0, start_made = 1'b0;
    logic tx_ack_clk = 1'b0, addr_acked = 1'b0, rx_ack_clk = 1'b0;
    logic addr_hit = 1'b0, gen_call_hit = 1'b0, arb_lost = 1'b0;
    logic sr_rd = 1'b0, dr_rd = 1'b0, dr_wr = 1'b0, start_wr = 1'b0;
    logic st_busy, st_byte_done, st_addr_sel, st_master, st_start_sent, irq, scl_hold_low;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    i2c_stat_stretch u_dut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .irq_en(irq_en), .ack_en(ack_en),
        .bus_start_seen(bus_start_seen), .bus_stop_seen(bus_stop_seen),
        .start_made(start_made), .tx_ack_clk(tx_ack_clk), .addr_acked(addr_acked),
        .rx_ack_clk(rx_ack_clk), .addr_hit(addr_hit), .gen_call_hit(gen_call_hit),
        .arb_lost(arb_lost), .sr_rd(sr_rd), .dr_rd(dr_rd), .dr_wr(dr_wr),
        .start_wr(start_wr), .st_busy(st_busy), .st_byte_done(st_byte_done),
        .st_addr_sel(st_addr_sel), .st_master(st_master), .st_start_sent(st_start_sent),
        .irq(irq), .scl_hold_low(scl_hold_low)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_sr_rd();
        sr_rd = 1'b1; tick(); sr_rd = 1'b0;
    endtask

    task automatic do_dr_rd();
        dr_rd = 1'b1; tick(); dr_rd = 1'b0;
    endtask

    task automatic do_dr_wr();
        dr_wr = 1'b1; tick(); dr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 busy",  st_busy, 1'b0);
        chk("R12 btf",   st_byte_done, 1'b0);
        chk("R12 adsl",  st_addr_sel, 1'b0);
        chk("R12 master", st_master, 1'b0);
        chk("R12 sb",    st_start_sent, 1'b0);
        chk("R12 irq",   irq, 1'b0);
        chk("R12 hold",  scl_hold_low, 1'b0);
    endtask

    task automatic t_busy();
        bus_start_seen = 1'b1; tick(); bus_start_seen = 1'b0;
        chk("R1 busy after start", st_busy, 1'b1);
        bus_stop_seen = 1'b1; tick(); bus_stop_seen = 1'b0;
        chk("R1 idle after stop", st_busy, 1'b0);
        if_en = 1'b0;
        bus_start_seen = 1'b1; tick(); bus_start_seen = 1'b0;
        chk("R1 busy tracks while disabled", st_busy, 1'b1);
        bus_stop_seen = 1'b1; tick(); bus_stop_seen = 1'b0;
        chk("R1 idle tracks while disabled", st_busy, 1'b0);
        if_en = 1'b1;
        tick();
    endtask

    task automatic t_btf_tx();
        tx_ack_clk = 1'b1; tick(); tx_ack_clk = 1'b0;
        chk("R2 btf after tx ack clock", st_byte_done, 1'b1);
        chk("R10 hold with btf", scl_hold_low, 1'b1);
        chk("R11 irq not yet", irq, 1'b0);
        tick();
        chk("R11 irq one cycle later", irq, 1'b1);
        do_sr_rd();
        chk("R4 status read alone keeps btf", st_byte_done, 1'b1);
        do_dr_wr();
        chk("R4 btf cleared by write", st_byte_done, 1'b0);
        chk("R10 hold released", scl_hold_low, 1'b0);
        tick();
        chk("R11 irq drops", irq, 1'b0);
    endtask

    task automatic t_btf_rx();
        ack_en = 1'b0;
        rx_ack_clk = 1'b1; tick(); rx_ack_clk = 1'b0;
        chk("R3 no btf without ack enable", st_byte_done, 1'b0);
        ack_en = 1'b1;
        rx_ack_clk = 1'b1; tick(); rx_ack_clk = 1'b0;
        chk("R3 btf after rx ack clock", st_byte_done, 1'b1);
        do_sr_rd();
        do_dr_wr();
        chk("R4 wrong access keeps rx btf", st_byte_done, 1'b1);
        do_dr_rd();
        chk("R4 disarmed read keeps btf", st_byte_done, 1'b1);
        do_sr_rd();
        do_dr_rd();
        chk("R4 status read then read clears", st_byte_done, 1'b0);
    endtask

    task automatic t_addr_ack();
        addr_acked = 1'b1; tick(); addr_acked = 1'b0;
        chk("R2 btf after address ack", st_byte_done, 1'b1);
        do_dr_wr();
        chk("R4 write without status read keeps btf", st_byte_done, 1'b1);
        do_sr_rd();
        do_dr_wr();
        chk("R2 address btf cleared by write", st_byte_done, 1'b0);
    endtask

    task automatic t_adsl();
        addr_hit = 1'b1; tick(); addr_hit = 1'b0;
        chk("R5 adsl on address hit", st_addr_sel, 1'b1);
        chk("R10 hold with adsl", scl_hold_low, 1'b1);
        chk("R5 btf untouched", st_byte_done, 1'b0);
        do_sr_rd();
        chk("R5 status read clears adsl", st_addr_sel, 1'b0);
        chk("R10 hold released after adsl", scl_hold_low, 1'b0);
        gen_call_hit = 1'b1; tick(); gen_call_hit = 1'b0;
        chk("R5 adsl on general call", st_addr_sel, 1'b1);
        do_dr_rd();
        chk("R5 data read alone keeps adsl", st_addr_sel, 1'b1);
        do_sr_rd();
        chk("R5 cleared again", st_addr_sel, 1'b0);
        tick();
    endtask

    task automatic t_sb_master();
        start_wr = 1'b1; tick(); start_wr = 1'b0;
        chk("R7 master after start write", st_master, 1'b1);
        start_made = 1'b1; tick(); start_made = 1'b0;
        chk("R6 sb after start made", st_start_sent, 1'b1);
        do_sr_rd();
        do_dr_rd();
        chk("R6 read does not clear sb", st_start_sent, 1'b1);
        do_sr_rd();
        do_dr_wr();
        chk("R6 address write clears sb", st_start_sent, 1'b0);
        arb_lost = 1'b1; tick(); arb_lost = 1'b0;
        chk("R7 arbitration loss drops master", st_master, 1'b0);
        start_wr = 1'b1; tick(); start_wr = 1'b0;
        chk("R7 master again", st_master, 1'b1);
        start_wr = 1'b1; bus_stop_seen = 1'b1; tick();
        start_wr = 1'b0; bus_stop_seen = 1'b0;
        chk("R7 stop beats start write", st_master, 1'b0);
        tick();
    endtask

    task automatic t_set_wins();
        start_made = 1'b1; tick(); start_made = 1'b0;
        do_sr_rd();
        dr_wr = 1'b1; start_made = 1'b1; tick();
        dr_wr = 1'b0; start_made = 1'b0;
        chk("R9 set beats clearing write", st_start_sent, 1'b1);
        addr_hit = 1'b1; sr_rd = 1'b1; tick();
        addr_hit = 1'b0; sr_rd = 1'b0;
        chk("R9 set beats clearing read", st_addr_sel, 1'b1);
        do_sr_rd();
        chk("R5 adsl cleared", st_addr_sel, 1'b0);
        do_dr_wr();
        chk("R6 sb cleared after set-wins", st_start_sent, 1'b0);
        tick();
    endtask

    task automatic t_disable();
        tx_ack_clk = 1'b1; addr_hit = 1'b1; start_made = 1'b1; start_wr = 1'b1;
        tick();
        tx_ack_clk = 1'b0; addr_hit = 1'b0; start_made = 1'b0; start_wr = 1'b0;
        chk("R8 pre btf", st_byte_done, 1'b1);
        chk("R8 pre master", st_master, 1'b1);
        if_en = 1'b0; tick();
        chk("R8 btf forced off", st_byte_done, 1'b0);
        chk("R8 adsl forced off", st_addr_sel, 1'b0);
        chk("R8 sb forced off", st_start_sent, 1'b0);
        chk("R8 master forced off", st_master, 1'b0);
        tx_ack_clk = 1'b1; addr_hit = 1'b1; start_wr = 1'b1; tick();
        tx_ack_clk = 1'b0; addr_hit = 1'b0; start_wr = 1'b0;
        chk("R8 btf not set while off", st_byte_done, 1'b0);
        chk("R8 adsl not set while off", st_addr_sel, 1'b0);
        chk("R8 master not set while off", st_master, 1'b0);
        chk("R11 irq off while disabled", irq, 1'b0);
        if_en = 1'b1; tick();
    endtask

    task automatic t_irq_mask();
        irq_en = 1'b0;
        addr_hit = 1'b1; tick(); addr_hit = 1'b0;
        tick();
        chk("R11 irq masked", irq, 1'b0);
        irq_en = 1'b1; tick();
        chk("R11 irq after unmask", irq, 1'b1);
        do_sr_rd();
        chk("R11 irq held one cycle after clear", irq, 1'b1);
        tick();
        chk("R11 irq gone", irq, 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        if_en = 1'b1; irq_en = 1'b1; ack_en = 1'b1;
        tick();
        t_busy();
        t_btf_tx();
        t_btf_rx();
        t_addr_ack();
        t_adsl();
        t_sb_master();
        t_set_wins();
        t_disable();
        t_irq_mask();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule